// File: doc/BRIEF.md
# Passive SPI configuration sequencer

This block is the host side of a passive serial configuration link. It loads a bitstream into a target programmable device. Bitstream bytes arrive on a valid/ready byte stream. The block drives the SPI clock, the MOSI data line, the chip select and an active-low reset line to the target. It also samples the target's configuration-done signal. A single start pulse runs the whole sequence, and the block finishes with one of three outcomes: a done status, a timeout error or a rejected-request error.

The sequence has eight steps:

1. Select the target.
2. Pulse its reset low.
3. Wait out the setup time.
4. Stream the bitstream out in SPI mode 3, most significant bit first.
5. Send a run of all-zero idle bytes.
6. Release the chip select.
7. Poll the done input against a programmable timeout.
8. Hold off a user-mode settle delay.

The hardware counts every delay in system clock cycles. The counts are derived from the clock frequency parameter. A request for partial reconfiguration is refused before any pin moves.

Top module: `pspi_cfg_loader`

## Requirements
- R1: After reset and while idle, spi_csn=1, spi_sclk=1 (clock idles high), tgt_rstn=1, s_ready=0, and busy, cfg_done, err_timeout and err_partial are all 0.
- R2: Data goes out in SPI mode 3. MOSI is set up before each SCLK rising edge, the target samples on the rising edges, and each byte is sent bit 7 first.
- R3: spi_csn falls before tgt_rstn falls and stays low, without interruption, through reset, setup, data and trailing idle bytes. Each accepted start gives exactly one chip select deassertion and one reset pulse.
- R4: tgt_rstn is held low for exactly RST_CYC system cycles, which is 200 at the defaults (1 µs at 200 MHz).
- R5: At least SETUP_CYC system cycles (7000 at the defaults, 35 µs) pass between tgt_rstn rising and the first SCLK falling edge.
- R6: After the byte marked by s_last, exactly 13 bytes of value 0x00 are clocked out, which is 104 SCLK rising edges. Only then does spi_csn rise, so a run of n bytes gives 8*(n+13) rising edges.
- R7: If tgt_done is not seen high within tmo_cyc cycles of the chip select release, err_timeout is set, busy falls and cfg_done stays 0.
- R8: Once tgt_done goes high, cfg_done rises and busy falls no sooner than USER_CYC cycles later (6000 at the defaults, 30 µs). The limit is USER_CYC+4 cycles, counting the input synchroniser.
- R9: If partial_req is 1 when start is taken in idle, err_partial is set, busy stays 0, and spi_csn, tgt_rstn and spi_sclk do not move.
- R10: A start pulse while busy is ignored. It causes no second reset pulse or chip select cycle and does not disturb the data stream.
- R11: While the byte stream stalls in the data phase, SCLK rests high and spi_csn stays low.
- R12: An accepted start clears cfg_done, err_timeout and err_partial.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse to begin a configuration run |
| partial_req | input | 1 | Marks the start as a partial reconfiguration request |
| tmo_cyc | input | TMO_W | Done polling timeout in system cycles |
| s_data | input | 8 | Bitstream byte |
| s_valid | input | 1 | s_data holds a byte |
| s_last | input | 1 | This byte is the final bitstream byte |
| s_ready | output | 1 | Block accepts the byte this cycle |
| spi_sclk | output | 1 | SPI clock, idles high |
| spi_mosi | output | 1 | SPI data to the target |
| spi_csn | output | 1 | Active-low chip select |
| tgt_rstn | output | 1 | Active-low reset to the target |
| tgt_done | input | 1 | Configuration done from the target (asynchronous) |
| busy | output | 1 | A run is in progress |
| cfg_done | output | 1 | Target reached user mode after the settle delay |
| err_timeout | output | 1 | Done was not seen in time |
| err_partial | output | 1 | Partial reconfiguration request refused |

## Verification
The bench measures the reset pulse width and the gap from reset release to the first SCLK falling edge in cycles. A design that shortens either would let data reach a target that is still resetting. A scoreboard reassembles the MOSI bytes on every rising SCLK edge and counts the trailing zero bytes. This catches a reversed bit order, a lost or duplicated byte, or a chip select released before the 104 idle clocks are complete.

The bench also does the following:
- It counts the chip select edges and reset pulses during a stalled stream with a second start pulse. A chip select that glitches or restarts shows up in those counts.
- It bounds the timeout and the user-mode delay windows.
- It checks that a partial request moves no pin.
- It checks that the error flags clear on the next run.

// File: rtl/pspi_cfg_pkg.sv
`timescale 1ns/1ps
package pspi_cfg_pkg;

    // Number of all-zero bytes sent after the bitstream (8 clocks each)
    localparam int IDLE_BYTES = 13;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEL,
        ST_RST,
        ST_SETUP,
        ST_DATA,
        ST_TAIL,
        ST_POLL,
        ST_USER
    } seq_st_e;

    // Registered pins toward the target
    typedef struct packed {
        logic csn;
        logic rstn;
    } tgt_pins_t;

    // Byte load request toward the shifter
    typedef struct packed {
        logic       ld;
        logic [7:0] dat;
    } sh_req_t;

    // Nanoseconds to cycles, rounded up
    function automatic int ns2cyc(input int ns, input int mhz);
        return (ns * mhz + 999) / 1000;
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    // A run keeps the chip select low in these states
    function automatic logic selected(input seq_st_e s);
        return (s == ST_SEL) || (s == ST_RST) || (s == ST_SETUP) ||
               (s == ST_DATA) || (s == ST_TAIL);
    endfunction

endpackage

// File: rtl/pspi_dly_timer.sv
`timescale 1ns/1ps
module pspi_dly_timer #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ld,
    input  logic [CW-1:0] val,
    output logic          zero
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (ld) begin
            cnt <= val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/pspi_byte_shifter.sv
`timescale 1ns/1ps
module pspi_byte_shifter #(
    parameter int HALF = 2,
    parameter int BW   = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ld,
    input  logic [BW-1:0] din,
    output logic          sclk,
    output logic          mosi,
    output logic          idle
);
    localparam int DW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam int NW = $clog2(BW);

    logic [BW-1:0] sh;
    logic [NW-1:0] bitn;
    logic [DW-1:0] div;
    logic          act;
    logic          hi;

    // Mode 3: each bit is a low half then a high half. Data moves at the
    // falling edge, so it is stable across the rising edge.
    always_ff @(posedge clk) begin
        if (rst) begin
            sh   <= '0;
            bitn <= '0;
            div  <= '0;
            act  <= 1'b0;
            hi   <= 1'b1;
        end else if (ld) begin
            sh   <= din;
            bitn <= '0;
            div  <= '0;
            act  <= 1'b1;
            hi   <= 1'b0;
        end else if (act) begin
            if (div == DW'(HALF - 1)) begin
                div <= '0;
                if (!hi) begin
                    hi <= 1'b1;
                end else if (bitn == NW'(BW - 1)) begin
                    act <= 1'b0;
                end else begin
                    hi   <= 1'b0;
                    bitn <= bitn + 1'b1;
                    sh   <= {sh[BW-2:0], 1'b0};
                end
            end else begin
                div <= div + 1'b1;
            end
        end
    end

    assign sclk = hi;
    assign mosi = sh[BW-1];
    assign idle = !act;
endmodule

// File: rtl/pspi_in_sync.sv
`timescale 1ns/1ps
module pspi_in_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) chain[0] <= rst ? 1'b0 : d;
            end else begin : g_next
                always_ff @(posedge clk) chain[i] <= rst ? 1'b0 : chain[i-1];
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/pspi_cfg_loader.sv
`timescale 1ns/1ps
module pspi_cfg_loader
    import pspi_cfg_pkg::*;
#(
    parameter int CLK_MHZ  = 200,
    parameter int SCK_HALF = 2,
    parameter int TMO_W    = 20,
    parameter int RST_NS   = 1000,
    parameter int SETUP_NS = 35000,
    parameter int USER_NS  = 30000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             partial_req,
    input  logic [TMO_W-1:0] tmo_cyc,
    input  logic [7:0]       s_data,
    input  logic             s_valid,
    input  logic             s_last,
    output logic             s_ready,
    output logic             spi_sclk,
    output logic             spi_mosi,
    output logic             spi_csn,
    output logic             tgt_rstn,
    input  logic             tgt_done,
    output logic             busy,
    output logic             cfg_done,
    output logic             err_timeout,
    output logic             err_partial
);
    localparam int RST_CYC   = ns2cyc(RST_NS, CLK_MHZ);
    localparam int SETUP_CYC = ns2cyc(SETUP_NS, CLK_MHZ);
    localparam int USER_CYC  = ns2cyc(USER_NS, CLK_MHZ);
    localparam int MAXC      = max3(RST_CYC, SETUP_CYC, USER_CYC);
    localparam int CW        = ($clog2(MAXC + 1) > TMO_W) ? $clog2(MAXC + 1) : TMO_W;
    localparam int TW        = $clog2(IDLE_BYTES + 1);

    seq_st_e       st, nxt;
    tgt_pins_t     pins;
    sh_req_t       req;
    logic          tmr_ld, tmr_zero;
    logic [CW-1:0] tmr_val;
    logic          sh_idle;
    logic          done_s;
    logic          last_q;
    logic [TW-1:0] tail_q;
    logic          start_ok, start_rej, hs;

    pspi_dly_timer #(.CW(CW)) u_tmr (
        .clk  (clk),
        .rst  (rst),
        .ld   (tmr_ld),
        .val  (tmr_val),
        .zero (tmr_zero)
    );

    pspi_byte_shifter #(.HALF(SCK_HALF), .BW(8)) u_sh (
        .clk  (clk),
        .rst  (rst),
        .ld   (req.ld),
        .din  (req.dat),
        .sclk (spi_sclk),
        .mosi (spi_mosi),
        .idle (sh_idle)
    );

    pspi_in_sync #(.STAGES(2)) u_dsync (
        .clk (clk),
        .rst (rst),
        .d   (tgt_done),
        .q   (done_s)
    );

    assign start_ok  = start && (st == ST_IDLE) && !partial_req;
    assign start_rej = start && (st == ST_IDLE) && partial_req;
    assign s_ready   = (st == ST_DATA) && sh_idle && !last_q;
    assign hs        = s_valid && s_ready;

    always_comb begin
        nxt     = st;
        tmr_ld  = 1'b0;
        tmr_val = '0;
        req     = '0;
        unique case (st)
            ST_IDLE: begin
                if (start_ok) nxt = ST_SEL;
            end
            ST_SEL: begin
                nxt     = ST_RST;
                tmr_ld  = 1'b1;
                tmr_val = CW'(RST_CYC - 1);
            end
            ST_RST: begin
                if (tmr_zero) begin
                    nxt     = ST_SETUP;
                    tmr_ld  = 1'b1;
                    tmr_val = CW'(SETUP_CYC - 1);
                end
            end
            ST_SETUP: begin
                if (tmr_zero) nxt = ST_DATA;
            end
            ST_DATA: begin
                if (hs) begin
                    req.ld  = 1'b1;
                    req.dat = s_data;
                end else if (last_q && sh_idle) begin
                    nxt = ST_TAIL;
                end
            end
            ST_TAIL: begin
                if (sh_idle) begin
                    if (tail_q != '0) begin
                        req.ld  = 1'b1;
                        req.dat = 8'h00;
                    end else begin
                        nxt     = ST_POLL;
                        tmr_ld  = 1'b1;
                        tmr_val = CW'(tmo_cyc);
                    end
                end
            end
            ST_POLL: begin
                if (done_s) begin
                    nxt     = ST_USER;
                    tmr_ld  = 1'b1;
                    tmr_val = CW'(USER_CYC - 1);
                end else if (tmr_zero) begin
                    nxt = ST_IDLE;
                end
            end
            ST_USER: begin
                if (tmr_zero) nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= ST_IDLE;
            pins        <= '{csn: 1'b1, rstn: 1'b1};
            last_q      <= 1'b0;
            tail_q      <= '0;
            cfg_done    <= 1'b0;
            err_timeout <= 1'b0;
            err_partial <= 1'b0;
        end else begin
            st        <= nxt;
            pins.csn  <= !selected(nxt);
            pins.rstn <= (nxt != ST_RST);
            if (start_ok) begin
                last_q      <= 1'b0;
                tail_q      <= TW'(IDLE_BYTES);
                cfg_done    <= 1'b0;
                err_timeout <= 1'b0;
                err_partial <= 1'b0;
            end
            if (start_rej) begin
                cfg_done    <= 1'b0;
                err_timeout <= 1'b0;
                err_partial <= 1'b1;
            end
            if (hs && s_last) last_q <= 1'b1;
            if ((st == ST_TAIL) && req.ld) tail_q <= tail_q - 1'b1;
            if ((st == ST_POLL) && !done_s && tmr_zero) err_timeout <= 1'b1;
            if ((st == ST_USER) && tmr_zero) cfg_done <= 1'b1;
        end
    end

    assign spi_csn  = pins.csn;
    assign tgt_rstn = pins.rstn;
    assign busy     = (st != ST_IDLE);
endmodule

// File: rtl/pspi_cfg_checker.sv
`timescale 1ns/1ps
module pspi_cfg_checker #(
    parameter int RST_CYC = 200
) (
    input logic clk,
    input logic rst,
    input logic s_ready,
    input logic spi_sclk,
    input logic spi_csn,
    input logic tgt_rstn,
    input logic busy,
    input logic cfg_done,
    input logic err_timeout,
    input logic err_partial
);
    int unsigned low_cnt;

    always_ff @(posedge clk) begin
        if (rst) low_cnt <= 0;
        else if (!tgt_rstn) low_cnt <= low_cnt + 1;
        else low_cnt <= 0;
    end

    // R3: select is already low the cycle before reset falls
    a_r3_cs_before_reset: assert property (@(posedge clk) disable iff (rst)
        $fell(tgt_rstn) |-> (!spi_csn && $past(!spi_csn)));

    // R3: select stays low through the reset pulse
    a_r3_cs_held_in_reset: assert property (@(posedge clk) disable iff (rst)
        !tgt_rstn |-> !spi_csn);

    // R1: clock rests high whenever the target is deselected
    a_r1_sclk_idle_deselected: assert property (@(posedge clk) disable iff (rst)
        spi_csn |-> spi_sclk);

    // R4: reset low width in cycles
    a_r4_rst_width: assert property (@(posedge clk) disable iff (rst)
        $rose(tgt_rstn) |-> (low_cnt >= RST_CYC));

    // R5: no byte is accepted unless selected and out of reset
    a_r5_ready_only_selected: assert property (@(posedge clk) disable iff (rst)
        s_ready |-> (!spi_csn && tgt_rstn));

    // R8: done is only reported once the run is over
    a_r8_done_not_busy: assert property (@(posedge clk) disable iff (rst)
        cfg_done |-> !busy);

    // R7: a run ends either done or timed out, never both
    a_r7_outcome_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(err_timeout && cfg_done));

    // R9: a refused request leaves every target pin quiet
    a_r9_partial_quiet: assert property (@(posedge clk) disable iff (rst)
        err_partial |-> (spi_csn && tgt_rstn && spi_sclk && !busy));
endmodule

bind pspi_cfg_loader pspi_cfg_checker #(.RST_CYC(RST_CYC)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .s_ready     (s_ready),
    .spi_sclk    (spi_sclk),
    .spi_csn     (spi_csn),
    .tgt_rstn    (tgt_rstn),
    .busy        (busy),
    .cfg_done    (cfg_done),
    .err_timeout (err_timeout),
    .err_partial (err_partial)
);

// File: tb/sim_pspi_cfg_loader.sv
`timescale 1ns/1ps
module sim_pspi_cfg_loader;
    localparam int RST_CYC   = 200;
    localparam int SETUP_CYC = 7000;
    localparam int USER_CYC  = 6000;
    localparam int IDLE_B    = 13;
    localparam int TMO_W     = 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic             start = 1'b0, partial_req = 1'b0;
    logic [TMO_W-1:0] tmo_cyc = '0;
    logic [7:0]       s_data = '0;
    logic             s_valid = 1'b0, s_last = 1'b0, tgt_done = 1'b0;
    logic             s_ready, spi_sclk, spi_mosi, spi_csn, tgt_rstn;
    logic             busy, cfg_done, err_timeout, err_partial;

    pspi_cfg_loader u0 (
        .clk(clk), .rst(rst), .start(start), .partial_req(partial_req),
        .tmo_cyc(tmo_cyc), .s_data(s_data), .s_valid(s_valid), .s_last(s_last),
        .s_ready(s_ready), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
        .spi_csn(spi_csn), .tgt_rstn(tgt_rstn), .tgt_done(tgt_done),
        .busy(busy), .cfg_done(cfg_done), .err_timeout(err_timeout),
        .err_partial(err_partial)
    );

    int n_chk = 0, n_fail = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Scoreboard queue: the driver pushes, the monitor pops
    logic [7:0] exp_q[$];
    logic       mon_clr = 1'b0;

    int   rst_low, gap_cnt, gap_rec, csn_rise, csn_fall, rstn_fall, sclk_fall;
    int   rises, bad_order, nbits;
    bit   gap_on;
    logic p_sclk, p_csn, p_rstn;
    logic [7:0] acc;

    always @(negedge clk) begin
        if (mon_clr) begin
            rst_low = 0; gap_cnt = 0; gap_rec = -1; gap_on = 0;
            csn_rise = 0; csn_fall = 0; rstn_fall = 0; sclk_fall = 0;
            rises = 0; bad_order = 0; nbits = 0; acc = '0;
        end else if (!rst) begin
            if (!tgt_rstn) rst_low++;
            if (p_rstn && !tgt_rstn) begin
                rstn_fall++;
                if (p_csn) bad_order++;
            end
            if (p_csn && !spi_csn) csn_fall++;
            if (!p_csn && spi_csn) csn_rise++;
            if (gap_on) gap_cnt++;
            if (!p_rstn && tgt_rstn) begin gap_on = 1; gap_cnt = 1; end
            if (p_sclk && !spi_sclk) begin
                sclk_fall++;
                if (gap_on) begin gap_rec = gap_cnt; gap_on = 0; end
            end
            if (!p_sclk && spi_sclk && !spi_csn) begin
                rises++;
                acc = {acc[6:0], spi_mosi};
                nbits++;
                if (nbits == 8) begin
                    nbits = 0;
                    if (exp_q.size() == 0) chk(0, "R6 extra byte", acc, -1);
                    else begin
                        automatic logic [7:0] e = exp_q.pop_front();
                        chk(acc == e, "R2 byte MSB first", acc, e);
                    end
                end
            end
        end
        p_sclk = spi_sclk; p_csn = spi_csn; p_rstn = tgt_rstn;
    end

    int cyc = 0;
    always @(negedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            chk(0, "watchdog expired", cyc, 150000);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    logic [7:0] pay [0:7];

    task automatic do_run(input int n, input int stall_at, input bit restart,
                          input int done_dly, input int tmo);
        int c;
        mon_clr = 1; @(negedge clk); mon_clr = 0;
        tgt_done = 0; tmo_cyc = TMO_W'(tmo);
        start = 1; @(negedge clk); start = 0;
        chk(busy && !cfg_done && !err_timeout && !err_partial, "R12 flags cleared on start",
            {busy, cfg_done, err_timeout, err_partial}, 4'b1000);
        for (int i = 0; i < n; i++) begin
            if (i == stall_at) begin
                s_valid = 0;
                repeat (40) @(negedge clk);
                chk(spi_sclk && !spi_csn, "R11 stall sclk high cs low", {spi_sclk, spi_csn}, 2'b10);
                repeat (20) @(negedge clk);
            end
            s_data = pay[i]; s_last = (i == n - 1); s_valid = 1;
            if (restart && i == 1) start = 1;
            while (!s_ready) @(negedge clk);
            exp_q.push_back(pay[i]);
            @(posedge clk); @(negedge clk);
            start = 0; s_valid = 0; s_last = 0;
        end
        for (int k = 0; k < IDLE_B; k++) exp_q.push_back(8'h00);
        while (!spi_csn) @(negedge clk);
        if (done_dly >= 0) begin
            repeat (done_dly) @(negedge clk);
            tgt_done = 1; c = 0;
            while (!cfg_done) begin @(negedge clk); c++; end
            chk(c >= USER_CYC && c <= USER_CYC + 4, "R8 user delay", c, USER_CYC);
            chk(!busy && !err_timeout, "R8 busy low at done", {busy, err_timeout}, 0);
        end else begin
            c = 0;
            while (busy) begin @(negedge clk); c++; end
            chk(c >= tmo && c <= tmo + 3, "R7 timeout window", c, tmo);
            chk(err_timeout && !cfg_done, "R7 timeout flag", {err_timeout, cfg_done}, 2'b10);
        end
        chk(rst_low == RST_CYC, "R4 reset low width", rst_low, RST_CYC);
        chk(gap_rec >= SETUP_CYC, "R5 setup gap", gap_rec, SETUP_CYC);
        chk(csn_rise == 1 && csn_fall == 1, "R3 single cs cycle", csn_rise * 10 + csn_fall, 11);
        chk(rstn_fall == 1 && bad_order == 0, "R3 cs before reset / R10 one pulse",
            rstn_fall * 10 + bad_order, 10);
        chk(rises == 8 * (n + IDLE_B), "R6 rising edge count", rises, 8 * (n + IDLE_B));
        chk(exp_q.size() == 0, "R6 trailing bytes all sent", exp_q.size(), 0);
        tgt_done = 0;
        repeat (5) @(negedge clk);
    endtask

    initial begin
        mon_clr = 1;
        repeat (5) @(negedge clk);
        rst = 0; mon_clr = 0;
        @(negedge clk);
        chk(spi_csn && spi_sclk && tgt_rstn && !s_ready, "R1 reset pins",
            {spi_csn, spi_sclk, tgt_rstn, s_ready}, 4'b1110);
        chk(!busy && !cfg_done && !err_timeout && !err_partial, "R1 reset status",
            {busy, cfg_done, err_timeout, err_partial}, 0);

        // R2 R3 R4 R5 R6 R8: plain run
        pay[0] = 8'hA5; pay[1] = 8'h3C; pay[2] = 8'h01; pay[3] = 8'h80;
        do_run(4, -1, 1'b0, 100, 20000);

        // R10 R11: stalled stream with a stray start
        pay[0] = 8'hFF; pay[1] = 8'h5A; pay[2] = 8'hC3; pay[3] = 8'h7E;
        pay[4] = 8'h00; pay[5] = 8'h96;
        do_run(6, 3, 1'b1, 0, 20000);

        // R9: partial request refused, no pin activity
        mon_clr = 1; @(negedge clk); mon_clr = 0;
        partial_req = 1; start = 1; @(negedge clk); start = 0; partial_req = 0;
        repeat (50) @(negedge clk);
        chk(err_partial && !busy, "R9 partial refused", {err_partial, busy}, 2'b10);
        chk(csn_fall == 0 && rstn_fall == 0 && sclk_fall == 0, "R9 no pin activity",
            csn_fall + rstn_fall + sclk_fall, 0);

        // R7 timeout (also R12: err_partial cleared on start)
        pay[0] = 8'h12; pay[1] = 8'h34;
        do_run(2, -1, 1'b0, -1, 500);

        // R12: err_timeout cleared by the next run
        pay[0] = 8'h69;
        do_run(1, -1, 1'b0, 0, 20000);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule